// File: doc/BRIEF.md
# Configurable Output and State Macrocell

This block is one macrocell of a programmable logic fabric. It takes one data sum term and one enable sum term from the array and turns them into a stored or combinational cell value. That value goes back to the array and, in the pin variant, to an inverting tristate output driver. A two-bit mode code picks one of three behaviours:

- a D register on the common output clock, with the enable term acting as a clock enable;
- a D register that loads on a rising edge of the enable term itself;
- a plain combinational path.

The fourth code is invalid. It falls back to the combinational path and raises a configuration-error flag.

The enable term has its own polarity bit. The pin variant also has a data polarity bit. That bit is applied ahead of the register, so a cleared register always reads 1 at the pin. A shared reset term clears the register asynchronously. A synchronous active-low reset gives the power-up clear. A preload port forces the register for test. The buried variant, chosen with the `IS_PIN` parameter, has no pin and ignores the data polarity bit. It still gives true and complemented feedback.

The logic-generated clock is not used as a real clock. The enable term is sampled on the common clock, and its rising edge is detected there. This keeps the block inside a single clock domain.

Top module: `out_state_cell`

## Requirements
- R1: With mode code {mode_clk_sel,mode_comb} = 2'b10, at a rising clk edge the register loads the polarity-adjusted data term when the effective enable (e_sum XOR pol_e) is 1, and holds its value otherwise.
- R2: With mode code 2'b00, the register loads the polarity-adjusted data term only at a clk edge where the effective enable is 1 and was 0 at the previous clk edge. Holding the enable high does not reload.
- R3: With mode code 2'b01, fb_true equals the polarity-adjusted data term at once, and pin_o is its complement (pin variant). The register is not loaded from the data path.
- R4: Mode code 2'b11 behaves as 2'b01 and drives cfg_err to 1. In every other code cfg_err is 0.
- R5: While rst_term is 1, the register is 0 with no clock edge needed. In the register modes, fb_true then reads 0 and pin_o reads 1. rst_term overrides every other input.
- R6: rst_n low at a clk edge clears the register and the stored previous enable value. Preload and data loading are ignored at that edge.
- R7: pol_e = 1 inverts the enable term before it is used as a clock enable or as an edge source.
- R8: In the register modes of the pin variant, pin_o is the complement of the stored bit. pol_d (1 = invert) is applied to d_sum before storage, so a cleared register gives pin_o = 1 whatever pol_d is.
- R9: In the pin variant, pin_oe follows oe_term.
- R10: fb_true is the cell value taken before the output buffer (the register in the register modes, the data term otherwise), and fb_comp is always its complement.
- R11: pl_en = 1 at a clk edge loads pl_d into the register in any mode and regardless of the enable term. Only the two resets take priority over it.
- R12: In the buried variant (IS_PIN = 0), pol_d has no effect, and pin_o and pin_oe are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common output clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| mode_clk_sel | input | 1 | Mode bit: 1 selects the clock-enable register |
| mode_comb | input | 1 | Mode bit: 1 selects the combinational path |
| pol_d | input | 1 | Data polarity, 1 inverts (pin variant only) |
| pol_e | input | 1 | Enable polarity, 1 inverts |
| d_sum | input | 1 | Data sum term from the array |
| e_sum | input | 1 | Enable or clock sum term from the array |
| rst_term | input | 1 | Shared reset product term, active high, asynchronous |
| oe_term | input | 1 | Output-enable product term |
| pl_en | input | 1 | Preload enable |
| pl_d | input | 1 | Preload value |
| pin_o | output | 1 | Inverted cell value driven to the pad |
| pin_oe | output | 1 | Tristate driver enable |
| fb_true | output | 1 | Feedback to the array, true form |
| fb_comp | output | 1 | Feedback to the array, complemented form |
| cfg_err | output | 1 | Invalid mode code in use |

## Verification
The hardest case to reach is the edge-clocked mode. There, a load needs the effective enable to be low at one edge and high at the next, with no preload or reset in between. Polarity flips or mode changes in the middle of a sequence can create or hide an edge.

Directed sequences build these edges on purpose, including a held-high enable that must not reload. Seeded random cycles then mix mode, polarity and preload changes against a bench model that tracks the previous enable value. The asynchronous reset term is also raised between clock edges, and the outputs are checked before the next edge arrives.

// File: rtl/mc_pkg.sv
// Shared types for the output/state macrocell.
// Assumes the mode code is formed as {mode_clk_sel, mode_comb}.
package mc_pkg;

    typedef enum logic [1:0] {
        MODE_SUMCLK = 2'b00,
        MODE_COMB   = 2'b01,
        MODE_CE     = 2'b10,
        MODE_BAD    = 2'b11
    } mc_mode_e;

    typedef struct packed {
        logic reg_mode;   // register drives the cell value
        logic ce_mode;    // enable term is a clock enable
        logic edge_mode;  // enable term edge acts as the clock
        logic err;        // invalid code in use
    } mc_ctl_t;

endpackage

// File: rtl/mc_mode_decode.sv
// Decodes the two architecture bits into per-path controls.
// Assumes the invalid code falls back to the combinational path.
module mc_mode_decode
    import mc_pkg::*;
(
    input  logic    mode_clk_sel,
    input  logic    mode_comb,
    output mc_ctl_t ctl
);

    mc_mode_e code;
    assign code = mc_mode_e'({mode_clk_sel, mode_comb});

    // Map each code to its control flags.
    always_comb begin
        ctl = '0;
        case (code)
            MODE_CE:     begin ctl.reg_mode = 1'b1; ctl.ce_mode = 1'b1; end
            MODE_SUMCLK: begin ctl.reg_mode = 1'b1; ctl.edge_mode = 1'b1; end
            MODE_COMB:   ctl = '0;
            MODE_BAD:    ctl.err = 1'b1;
            default:     ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_load_gen.sv
// Produces the register load strobe from the enable sum term.
// The logic-generated clock is handled as a rising edge of the effective
// enable, sampled on the common clock. Assumes synchronous active-low reset.
module mc_load_gen
    import mc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  mc_ctl_t ctl,
    input  logic    e_sum,
    input  logic    pol_e,
    output logic    load
);

    logic e_eff;
    logic e_prev;

    assign e_eff = e_sum ^ pol_e;

    // Remember the effective enable seen at the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) e_prev <= 1'b0;
        else        e_prev <= e_eff;
    end

    // Choose the level or the edge of the enable as the load condition.
    always_comb begin
        load = 1'b0;
        if (ctl.ce_mode)        load = e_eff;
        else if (ctl.edge_mode) load = e_eff & ~e_prev;
    end

endmodule

// File: rtl/mc_state_reg.sv
// Macrocell storage bit. The array reset term clears it asynchronously, and
// rst_n clears it synchronously. Priority below those: preload, then load.
module mc_state_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic d,
    input  logic pl_en,
    input  logic pl_d,
    output logic q
);

    // Update the stored bit: async clear, sync reset, preload, data load.
    always_ff @(posedge clk or posedge clr) begin
        if (clr)         q <= 1'b0;
        else if (!rst_n) q <= 1'b0;
        else if (pl_en)  q <= pl_d;
        else if (load)   q <= d;
    end

endmodule

// File: rtl/mc_out_stage.sv
// Selects the cell value and drives feedback and, for pin cells, the
// inverting tristate buffer. Buried cells drive no pin.
module mc_out_stage
    import mc_pkg::*;
#(
    parameter bit IS_PIN = 1'b1
) (
    input  mc_ctl_t ctl,
    input  logic    q,
    input  logic    d_eff,
    input  logic    oe_term,
    output logic    pin_o,
    output logic    pin_oe,
    output logic    fb_true,
    output logic    fb_comp
);

    logic cell_val;

    // Pick the register or the combinational data as the cell value.
    always_comb cell_val = ctl.reg_mode ? q : d_eff;

    assign fb_true = cell_val;
    assign fb_comp = ~cell_val;

    generate
        if (IS_PIN) begin : g_pin
            assign pin_o  = ~cell_val;
            assign pin_oe = oe_term;
        end else begin : g_buried
            logic unused_oe;
            assign unused_oe = oe_term;
            assign pin_o  = 1'b0;
            assign pin_oe = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/out_state_cell.sv
// Configurable output or buried-state macrocell.
// Assumes a single common clock. The enable-term clock is edge-detected on clk.
module out_state_cell
    import mc_pkg::*;
#(
    parameter bit IS_PIN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_clk_sel,
    input  logic mode_comb,
    input  logic pol_d,
    input  logic pol_e,
    input  logic d_sum,
    input  logic e_sum,
    input  logic rst_term,
    input  logic oe_term,
    input  logic pl_en,
    input  logic pl_d,
    output logic pin_o,
    output logic pin_oe,
    output logic fb_true,
    output logic fb_comp,
    output logic cfg_err
);

    localparam bit USE_POL = IS_PIN;

    mc_ctl_t ctl;
    logic    load;
    logic    q;
    logic    d_eff;

    assign d_eff   = d_sum ^ (pol_d & USE_POL);
    assign cfg_err = ctl.err;

    mc_mode_decode u_dec (
        .mode_clk_sel (mode_clk_sel),
        .mode_comb    (mode_comb),
        .ctl          (ctl)
    );

    mc_load_gen u_load (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .e_sum (e_sum),
        .pol_e (pol_e),
        .load  (load)
    );

    mc_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rst_term),
        .load  (load),
        .d     (d_eff),
        .pl_en (pl_en),
        .pl_d  (pl_d),
        .q     (q)
    );

    mc_out_stage #(.IS_PIN(IS_PIN)) u_out (
        .ctl     (ctl),
        .q       (q),
        .d_eff   (d_eff),
        .oe_term (oe_term),
        .pin_o   (pin_o),
        .pin_oe  (pin_oe),
        .fb_true (fb_true),
        .fb_comp (fb_comp)
    );

endmodule

// File: rtl/mc_cell_chk.sv
// Port-level properties of the macrocell, attached to every instance by bind.
module mc_cell_chk #(
    parameter bit IS_PIN = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic mode_clk_sel,
    input logic mode_comb,
    input logic pol_d,
    input logic pol_e,
    input logic d_sum,
    input logic e_sum,
    input logic rst_term,
    input logic pl_en,
    input logic pl_d,
    input logic pin_o,
    input logic fb_true,
    input logic cfg_err
);

    logic dval;
    assign dval = d_sum ^ (pol_d & IS_PIN);

    // R1: enabled clock-enable mode loads the data term.
    a_r1_ce_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_clk_sel && !mode_comb && (e_sum ^ pol_e) && !pl_en && !rst_term)
        |=> (rst_term || mode_comb || fb_true == $past(dval)));

    // R1: disabled clock-enable mode holds its value.
    a_r1_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_clk_sel && !mode_comb && !(e_sum ^ pol_e) && !pl_en && !rst_term)
        |=> (rst_term || mode_comb || fb_true == $past(fb_true)));

    // R4: the invalid code passes the data term straight through.
    a_r4_bad_comb: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (fb_true == dval));

    // R5: the reset term holds a register-mode cell at 0.
    a_r5_async_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_term && !mode_comb) |-> !fb_true);

    // R11: preload wins over the data path.
    a_r11_preload: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_en && !rst_term)
        |=> (rst_term || mode_comb || fb_true == $past(pl_d)));

    // R8: the pin shows the complement of the stored bit.
    a_r8_pin_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_PIN && !mode_comb) |-> (pin_o == !fb_true));

endmodule

bind out_state_cell mc_cell_chk #(.IS_PIN(IS_PIN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_clk_sel (mode_clk_sel),
    .mode_comb    (mode_comb),
    .pol_d        (pol_d),
    .pol_e        (pol_e),
    .d_sum        (d_sum),
    .e_sum        (e_sum),
    .rst_term     (rst_term),
    .pl_en        (pl_en),
    .pl_d         (pl_d),
    .pin_o        (pin_o),
    .fb_true      (fb_true),
    .cfg_err      (cfg_err)
);

// File: tb/tb_out_state_cell.sv
module tb_out_state_cell;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_clk_sel = 0, mode_comb = 0, pol_d = 0, pol_e = 0;
    logic d_sum = 0, e_sum = 0, rst_term = 0, oe_term = 0, pl_en = 0, pl_d = 0;
    logic pin_o, pin_oe, fb_true, fb_comp, cfg_err;
    logic b_pin_o, b_pin_oe, b_fb_true, b_fb_comp, b_cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model state.
    logic mq_p = 0, mq_b = 0, me_prev = 0;

    always #2 clk = ~clk;

    out_state_cell #(.IS_PIN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .mode_clk_sel(mode_clk_sel), .mode_comb(mode_comb),
        .pol_d(pol_d), .pol_e(pol_e), .d_sum(d_sum), .e_sum(e_sum),
        .rst_term(rst_term), .oe_term(oe_term), .pl_en(pl_en), .pl_d(pl_d),
        .pin_o(pin_o), .pin_oe(pin_oe), .fb_true(fb_true), .fb_comp(fb_comp),
        .cfg_err(cfg_err)
    );

    out_state_cell #(.IS_PIN(1'b0)) dut_b (
        .clk(clk), .rst_n(rst_n), .mode_clk_sel(mode_clk_sel), .mode_comb(mode_comb),
        .pol_d(pol_d), .pol_e(pol_e), .d_sum(d_sum), .e_sum(e_sum),
        .rst_term(rst_term), .oe_term(oe_term), .pl_en(pl_en), .pl_d(pl_d),
        .pin_o(b_pin_o), .pin_oe(b_pin_oe), .fb_true(b_fb_true), .fb_comp(b_fb_comp),
        .cfg_err(b_cfg_err)
    );

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag();
        case ({mode_clk_sel, mode_comb})
            2'b10:   return "R1";
            2'b00:   return "R2";
            2'b01:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // Compare all outputs with the model, before the next edge.
    task automatic check_outputs(string tag);
        logic regm, vp, vb;
        if (rst_term) begin mq_p = 0; mq_b = 0; end
        regm = !mode_comb;
        vp = regm ? mq_p : (d_sum ^ pol_d);
        vb = regm ? mq_b : d_sum;
        chk({tag, " R10 fb_true"}, fb_true, vp);
        chk({tag, " R10 fb_comp"}, fb_comp, ~vp);
        chk({tag, " R8 pin_o"}, pin_o, ~vp);
        chk({tag, " R9 pin_oe"}, pin_oe, oe_term);
        chk({tag, " R4 cfg_err"}, cfg_err, mode_clk_sel & mode_comb);
        chk({tag, " R12 buried fb"}, b_fb_true, vb);
        chk({tag, " R12 buried pin"}, b_pin_o | b_pin_oe, 1'b0);
    endtask

    // Advance the model by one clock edge.
    task automatic model_edge();
        logic e_eff, ld;
        e_eff = e_sum ^ pol_e;
        ld = !mode_comb && (mode_clk_sel ? e_eff : (e_eff & ~me_prev));
        if (rst_term || !rst_n) begin mq_p = 0; mq_b = 0; end
        else if (pl_en)         begin mq_p = pl_d; mq_b = pl_d; end
        else if (ld)            begin mq_p = d_sum ^ pol_d; mq_b = d_sum; end
        me_prev = rst_n ? e_eff : 1'b0;
    endtask

    // Check outputs with the current inputs, then take one edge.
    task automatic step(string tag);
        #1;
        check_outputs(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic set_in(logic cks, logic cmb, logic pd, logic pe, logic d, logic e);
        mode_clk_sel = cks; mode_comb = cmb; pol_d = pd; pol_e = pe; d_sum = d; e_sum = e;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        // R6: power-up reset.
        set_in(0, 0, 0, 0, 1, 1);
        pl_en = 1; pl_d = 1;
        step("R6 reset"); step("R6 reset");
        rst_n = 1; pl_en = 0; e_sum = 0;
        #1;
        chk("R6 reset fb", fb_true, 1'b0);
        chk("R8 reset pin high", pin_o, 1'b1);
        step("R6 post");

        // R1: clock enable loads, then holds.
        set_in(1, 0, 0, 0, 1, 1); step("R1 load");
        set_in(1, 0, 0, 0, 0, 0); step("R1 hold");
        #1; chk("R1 held value", fb_true, 1'b1);

        // R7: inverted enable: e_sum=0 is active.
        set_in(1, 0, 0, 1, 0, 0); step("R7 inv enable");
        #1; chk("R7 loaded via pol_e", fb_true, 1'b0);

        // R2: edge clock loads once, then holds with E high.
        set_in(0, 0, 0, 0, 0, 0); step("R2 low");
        set_in(0, 0, 0, 0, 1, 1); step("R2 rise");
        #1; chk("R2 loaded on rise", fb_true, 1'b1);
        set_in(0, 0, 0, 0, 0, 1); step("R2 held high");
        #1; chk("R2 no reload", fb_true, 1'b1);

        // R5: async clear between edges.
        #1; rst_term = 1; #0.5;
        chk("R5 async fb", fb_true, 1'b0);
        chk("R5 async pin", pin_o, 1'b1);
        step("R5 held");
        rst_term = 0;

        // R8: polarity applied before storage; clear still gives pin 1.
        set_in(1, 0, 1, 0, 0, 1); step("R8 pol store");
        #1; chk("R8 stored inverted", pin_o, 1'b0);
        rst_term = 1; #1;
        chk("R8 pin high after clear", pin_o, 1'b1);
        step("R8 clr"); rst_term = 0;

        // R11: preload with enable inactive.
        set_in(1, 0, 0, 0, 0, 0); pl_en = 1; pl_d = 1; step("R11 preload");
        pl_en = 0; #1; chk("R11 preload value", fb_true, 1'b1);

        // R3 / R4: combinational and invalid codes.
        set_in(0, 1, 0, 0, 1, 1); step("R3 comb");
        set_in(1, 1, 1, 0, 1, 0); step("R4 bad");
        #1; chk("R4 cfg_err set", cfg_err, 1'b1);

        // Random mix.
        for (int i = 0; i < 600; i++) begin
            set_in($urandom_range(1), $urandom_range(1), $urandom_range(1),
                   $urandom_range(1), $urandom_range(1), $urandom_range(1));
            oe_term  = $urandom_range(1);
            pl_en    = ($urandom_range(7) == 0);
            pl_d     = $urandom_range(1);
            rst_term = ($urandom_range(15) == 0);
            rst_n    = ($urandom_range(31) != 0);
            step(mode_tag());
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule